// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block sends a message of one or more bytes over the monitor slot of a time-division frame interface. It uses a two-wire handshake of active-low flags: the block drives a transmit-valid flag (`mx_n_o`) and reads back an acknowledge flag (`mr_n_i`) from the far end. Once per frame, marked by a single-cycle `frame_i` strobe, the block updates the slot byte and the flag it drives. At the same strobe it samples the acknowledge flag for the frame that has just ended. Bit-level serialisation of the slot and the receive direction belong to the surrounding logic.

The local side hands over bytes on a valid/ready stream with a last-byte marker. `s_ready` is high only in the strobe cycle, and only when the block can take a byte. It never depends on `s_valid`. A byte moves when both are high in that cycle. Back-pressure needs nothing special from the source: it keeps `s_valid`, `s_data` and `s_last` steady until a strobe in which `s_ready` is high. The source may also hold `s_valid` low for any number of frames. Between bytes of one message, the block keeps the current byte on the slot with the flag active until the next byte arrives.

Each byte after the first is preceded by a single frame with the flag inactive. The end of a message is marked by keeping the flag inactive for at least two frames. If the far end does not acknowledge within a set number of frames, the block raises an error, drops the flag and returns to idle.

Top module: `mon_tx_ctrl`

## Requirements
- R1: While no message is in progress (after reset, after an end of message, after a timeout), the slot byte is all ones (0xFF) and `mx_n_o` is 1.
- R2: `mon_byte_o`, `mx_n_o` and `err_o` change only on the clock edge at which `frame_i` is 1. `s_ready` is 1 only while `frame_i` is 1, and a byte is taken when `s_valid` and `s_ready` are both 1.
- R3: A message starts only at a strobe that closes the second or a later consecutive frame in which `mx_n_o` and `mr_n_i` were both 1. In the frame that follows, the first byte is on the slot and `mx_n_o` is 0.
- R4: A byte stays on the slot with `mx_n_o` at 0 until it is acknowledged. An acknowledge is `mr_n_i` sampled 0 at a strobe, after `mr_n_i` has been sampled 1 at some strobe since the previous acknowledge.
- R5: After a byte without the last marker is acknowledged, `mx_n_o` stays 0 and the byte stays unchanged until the next byte is taken.
- R6: A byte taken after the first is shown with `mx_n_o` at 1 for exactly one frame. It is then shown, unchanged, with `mx_n_o` at 0.
- R7: After the byte carrying the last marker is acknowledged, `mx_n_o` is 1 and the slot is 0xFF for at least two frames.
- R8: If TO_FRAMES strobes pass in the waiting state with no acknowledge, then at the last of them `err_o` goes to 1, `mx_n_o` to 1 and the slot to 0xFF. `err_o` stays 1 until the next message starts. It never rises during a run that is acknowledged in time.
- R9: The far end receives the bytes in the order they were taken, including bytes of value 0xFF, with message boundaries where the last marker was set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe at each frame boundary |
| s_valid | input | 1 | Local byte valid |
| s_ready | output | 1 | Block takes the byte in this cycle |
| s_data | input | DATA_W | Local byte |
| s_last | input | 1 | Byte is the last of its message |
| mon_byte_o | output | DATA_W | Byte for the outgoing monitor slot |
| mx_n_o | output | 1 | Transmit flag, active low |
| mr_n_i | input | 1 | Acknowledge flag from the far end, active low |
| err_o | output | 1 | Acknowledge timeout seen in the current or last message |

## Verification
The assertions assume that `frame_i` is a single-cycle pulse and that `mr_n_i` and the stream inputs change only away from the strobe edge. The bench meets this by driving every input on the falling clock edge, with strobes several cycles apart. The checks on the handshake also assume a far end that raises its acknowledge flag after each flag release and lowers it again only to acknowledge. The bench's far-end model follows this rule, with random acknowledge delays that stay well below the timeout. The only departures are the directed cases, which either hold the acknowledge low during idle or withhold it altogether.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // slot idle, flag inactive
    ST_WAIT = 2'd1,  // byte shown, awaiting acknowledge
    ST_HOLD = 2'd2,  // byte acknowledged, awaiting next local byte
    ST_REL  = 2'd3   // one-frame flag release with next byte shown
  } mtx_state_e;
endpackage

// File: rtl/mon_tx_idle_gate.sv
// Counts consecutive frames in which both flags were inactive and
// tells the sequencer when a new message may begin.
module mon_tx_idle_gate #(
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  input  logic mx_n,
  input  logic mr_n,
  output logic idle_ok
);
  localparam int CW = $clog2(IDLE_FRAMES + 1);

  logic [CW-1:0] cnt_q;
  logic          both_hi;

  always_comb begin
    both_hi = mx_n & mr_n;
    idle_ok = both_hi && (cnt_q >= CW'(IDLE_FRAMES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (frame_i) begin
      if (!both_hi)
        cnt_q <= '0;
      else if (cnt_q < CW'(IDLE_FRAMES))
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mon_tx_ack_detect.sv
// An acknowledge is the flag sampled low after it has been sampled high
// at least once since the previous acknowledge.
module mon_tx_ack_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  input  logic mr_n,
  input  logic waiting,
  output logic ack_o
);
  logic armed_q;

  always_comb ack_o = frame_i & waiting & ~mr_n & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (frame_i) begin
      if (mr_n)
        armed_q <= 1'b1;
      else if (ack_o)
        armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_tx_timeout.sv
// Frame counter for the acknowledge wait; TO_FRAMES = 0 removes it.
module mon_tx_timeout #(
  parameter int TO_FRAMES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  input  logic clear_i,
  input  logic count_i,
  output logic expire_o
);
  generate
    if (TO_FRAMES == 0) begin : g_off
      always_comb expire_o = 1'b0;
      logic unused_ok;
      always_comb unused_ok = &{1'b0, clk, rst_n, frame_i, clear_i, count_i};
    end else begin : g_on
      localparam int CW = $clog2(TO_FRAMES + 1);
      logic [CW-1:0] cnt_q;

      always_comb expire_o = frame_i & count_i & (cnt_q == CW'(TO_FRAMES - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (clear_i)
          cnt_q <= '0;
        else if (frame_i && count_i && (cnt_q < CW'(TO_FRAMES - 1)))
          cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/mon_tx_ctrl.sv
module mon_tx_ctrl #(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2,
  parameter int TO_FRAMES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic [DATA_W-1:0] mon_byte_o,
  output logic              mx_n_o,
  input  logic              mr_n_i,
  output logic              err_o
);
  import mon_tx_pkg::*;

  localparam logic [DATA_W-1:0] IDLE_FILL = {DATA_W{1'b1}};

  mtx_state_e        state_q, state_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              last_q, last_d;
  logic              mx_q, mx_d;
  logic              err_q, err_d;

  logic idle_ok, ack, expire, take, to_clear, to_count;

  mon_tx_idle_gate #(.IDLE_FRAMES(IDLE_FRAMES)) u_idle (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .mx_n(mx_q), .mr_n(mr_n_i), .idle_ok(idle_ok)
  );

  mon_tx_ack_detect u_ack (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .mr_n(mr_n_i), .waiting(state_q == ST_WAIT), .ack_o(ack)
  );

  mon_tx_timeout #(.TO_FRAMES(TO_FRAMES)) u_to (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .clear_i(to_clear), .count_i(to_count), .expire_o(expire)
  );

  always_comb begin
    s_ready  = frame_i && (((state_q == ST_IDLE) && idle_ok) || (state_q == ST_HOLD));
    take     = s_valid && s_ready;
    to_clear = take || (frame_i && (state_q == ST_REL));
    to_count = (state_q == ST_WAIT) && !ack;
  end

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    last_d  = last_q;
    mx_d    = mx_q;
    err_d   = err_q;
    if (frame_i) begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_d = ST_WAIT;
          byte_d  = s_data;
          last_d  = s_last;
          mx_d    = 1'b0;
          err_d   = 1'b0;
        end
        ST_WAIT: if (ack) begin
          if (last_q) begin
            state_d = ST_IDLE;
            mx_d    = 1'b1;
            byte_d  = IDLE_FILL;
          end else begin
            state_d = ST_HOLD;
          end
        end else if (expire) begin
          state_d = ST_IDLE;
          mx_d    = 1'b1;
          byte_d  = IDLE_FILL;
          err_d   = 1'b1;
        end
        ST_HOLD: if (take) begin
          state_d = ST_REL;
          byte_d  = s_data;
          last_d  = s_last;
          mx_d    = 1'b1;
        end
        ST_REL: begin
          state_d = ST_WAIT;
          mx_d    = 1'b0;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= IDLE_FILL;
      last_q  <= 1'b0;
      mx_q    <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      mx_q    <= mx_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    mon_byte_o = byte_q;
    mx_n_o     = mx_q;
    err_o      = err_q;
  end
endmodule

// File: rtl/mon_tx_chk.sv
module mon_tx_chk #(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_i,
  input logic              s_ready,
  input logic              mr_n_i,
  input logic              mx_n_o,
  input logic              err_o,
  input logic [DATA_W-1:0] mon_byte_o
);
  logic [7:0] hi_run, both_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      both_run <= '0;
    end else if (frame_i) begin
      hi_run   <= !mx_n_o ? 8'd0 : (hi_run == 8'hFF ? hi_run : hi_run + 8'd1);
      both_run <= !(mx_n_o && mr_n_i) ? 8'd0 : (both_run == 8'hFF ? both_run : both_run + 8'd1);
    end
  end

  AST_OUT_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_i) |-> ($stable(mx_n_o) && $stable(mon_byte_o) && $stable(err_o))); // R2
  AST_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> frame_i); // R2
  AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mx_n_o) |-> ((hi_run == 8'd1) || (both_run >= 8'(IDLE_FRAMES)))); // R3
  AST_BYTE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mx_n_o && !$past(mx_n_o)) |-> $stable(mon_byte_o)); // R4
  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mx_n_o && (hi_run != 8'd0)) |-> (mon_byte_o == {DATA_W{1'b1}})); // R7
  AST_ERR_DROPS_MX: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> mx_n_o); // R8
  AST_ERR_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !$past(mx_n_o)); // R8
endmodule

bind mon_tx_ctrl mon_tx_chk #(.DATA_W(DATA_W), .IDLE_FRAMES(IDLE_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .s_ready(s_ready),
  .mr_n_i(mr_n_i), .mx_n_o(mx_n_o), .err_o(err_o), .mon_byte_o(mon_byte_o)
);

// File: tb/tb_mon_tx_ctrl.sv
`timescale 1ns/1ps
module tb_mon_tx_ctrl;
  localparam int DW = 8;
  localparam int TO = 16;
  localparam int FRAME_CYC = 6;

  logic clk = 1'b0, rst_n = 1'b0, frame_i = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, mx_n_o, err_o, mr_n_i;
  logic [DW-1:0] mon_byte_o;

  bit mr_model = 1'b1, force_low = 1'b0, mute = 1'b0;
  assign mr_n_i = force_low ? 1'b0 : mr_model;

  always #2 clk = ~clk;

  mon_tx_ctrl #(.DATA_W(DW), .IDLE_FRAMES(2), .TO_FRAMES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .mon_byte_o(mon_byte_o), .mx_n_o(mx_n_o),
    .mr_n_i(mr_n_i), .err_o(err_o)
  );

  int checks = 0, errors = 0;
  int rx_st = 0, seen = 0, dly = 1, hi = 0, dmax = 0, hold = 0, gap_max = 0, acks = 0;
  logic [DW-1:0] cur = '0, rel_b = '0;
  logic [DW-1:0] q_d[$], sent_d[$], rx_d[$];
  bit q_l[$], sent_l[$], rx_l[$];

  function automatic logic [DW-1:0] idle_fill();
    return {DW{1'b1}};
  endfunction

  function automatic int frames_to_error();
    return TO;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Far-end model: decides MR for the next frame from the frame just ended.
  task automatic model_step(bit mx, logic [DW-1:0] b);
    if (!mx) begin
      case (rx_st)
        0: begin cur = b; seen = 0; rx_st = 1; dly = 1 + $urandom_range(0, dmax); end
        2: chk(b == cur, "R5 byte held while next byte deferred", b, cur);
        3: begin
          chk(hi == 1, "R6 release lasts one frame", hi, 1);
          chk(b == rel_b, "R6 byte of release frame kept", b, rel_b);
          cur = b; seen = 0; rx_st = 1; dly = 1 + $urandom_range(0, dmax);
        end
        default: chk(b == cur, "R4 byte held until acknowledge", b, cur);
      endcase
      if (rx_st == 1) begin
        seen++;
        if (seen >= dly && !mute) begin
          mr_model = 1'b0;
          rx_d.push_back(cur);
          rx_l.push_back(1'b0);
          acks++;
          rx_st = 2;
        end
      end
    end else begin
      case (rx_st)
        0: chk(b == idle_fill(), "R1 idle slot is all ones", b, idle_fill());
        1: rx_st = 0;
        2: begin rel_b = b; hi = 1; mr_model = 1'b1; rx_st = 3; end
        default: begin
          hi++;
          chk(b == idle_fill(), "R7 end-of-message slot is all ones", b, idle_fill());
          rx_l[rx_l.size()-1] = 1'b1;
          rx_st = 0;
        end
      endcase
    end
  endtask

  task automatic do_frame();
    bit mx, took;
    logic [DW-1:0] b;
    @(negedge clk);
    mx = mx_n_o;
    b  = mon_byte_o;
    frame_i = 1'b1;
    if (q_d.size() > 0 && hold == 0) begin
      s_valid = 1'b1; s_data = q_d[0]; s_last = q_l[0];
    end else begin
      s_valid = 1'b0;
    end
    #1;
    took = s_valid && s_ready;
    @(negedge clk);
    frame_i = 1'b0;
    s_valid = 1'b0;
    if (took) begin
      sent_d.push_back(q_d.pop_front());
      sent_l.push_back(q_l.pop_front());
      hold = $urandom_range(0, gap_max);
    end else if (hold > 0) begin
      hold--;
    end
    model_step(mx, b);
    repeat (FRAME_CYC - 2) @(negedge clk);
  endtask

  task automatic drain();
    for (int g = 0; g < 4000 && (q_d.size() > 0 || rx_st != 0); g++) do_frame();
    repeat (3) do_frame();
  endtask

  task automatic wait_start();
    for (int g = 0; g < 10 && mx_n_o; g++) do_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mx_n_o == 1'b1, "R1 reset flag inactive", mx_n_o, 1);
    chk(mon_byte_o == idle_fill(), "R1 reset slot all ones", mon_byte_o, idle_fill());
    chk(err_o == 1'b0, "R8 reset error clear", err_o, 0);
    chk(s_ready == 1'b0, "R2 no ready outside strobe", s_ready, 0);

    // R3: start only after two idle frames
    q_d.push_back(8'h5A); q_l.push_back(1'b1);
    do_frame();
    chk(mx_n_o == 1'b1, "R3 no start after one idle frame", mx_n_o, 1);
    do_frame();
    chk(mx_n_o == 1'b0, "R3 start after two idle frames", mx_n_o, 0);
    chk(mon_byte_o == 8'h5A, "R3 first byte with flag", mon_byte_o, 8'h5A);
    drain();

    // R5: deferred next byte
    q_d.push_back(8'h3C); q_l.push_back(1'b0);
    begin
      int a0 = acks;
      for (int g = 0; g < 20 && acks == a0; g++) do_frame();
    end
    do_frame();
    for (int k = 0; k < 4; k++) begin
      do_frame();
      chk(mx_n_o == 1'b0, "R5 flag kept active while no byte", mx_n_o, 0);
      chk(mon_byte_o == 8'h3C, "R5 byte kept while no byte", mon_byte_o, 8'h3C);
    end
    q_d.push_back(8'hC3); q_l.push_back(1'b1);
    drain();

    // R3: far end holding MR low blocks the start
    force_low = 1'b1;
    q_d.push_back(8'h77); q_l.push_back(1'b1);
    for (int k = 0; k < 4; k++) begin
      do_frame();
      chk(mx_n_o == 1'b1, "R3 MR low blocks start", mx_n_o, 1);
    end
    force_low = 1'b0;
    do_frame();
    chk(mx_n_o == 1'b1, "R3 one idle frame after MR release", mx_n_o, 1);
    do_frame();
    chk(mx_n_o == 1'b0 && mon_byte_o == 8'h77, "R3 start after two frames of MR high", mon_byte_o, 8'h77);
    drain();

    // Random traffic
    gap_max = 2;
    dmax = 2;
    for (int m = 0; m < 30; m++) begin
      int len = 1 + $urandom_range(0, 3);
      for (int i = 0; i < len; i++) begin
        q_d.push_back(($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom));
        q_l.push_back(i == len - 1);
      end
    end
    drain();
    chk(err_o == 1'b0, "R8 no error with timely acknowledges", err_o, 0);

    chk(rx_d.size() == sent_d.size(), "R9 byte count received", rx_d.size(), sent_d.size());
    for (int i = 0; i < sent_d.size() && i < rx_d.size(); i++) begin
      chk(rx_d[i] == sent_d[i], "R9 byte order and value", rx_d[i], sent_d[i]);
      chk(rx_l[i] == sent_l[i], "R7 message boundary", rx_l[i], sent_l[i]);
    end

    // R8: timeout
    gap_max = 0;
    dmax = 0;
    mute = 1'b1;
    q_d.push_back(8'h99); q_l.push_back(1'b1);
    wait_start();
    repeat (frames_to_error() - 1) do_frame();
    chk(err_o == 1'b0 && mx_n_o == 1'b0, "R8 no timeout before limit", err_o, 0);
    do_frame();
    chk(err_o == 1'b1, "R8 error at limit", err_o, 1);
    chk(mx_n_o == 1'b1 && mon_byte_o == idle_fill(), "R8 slot released at timeout", mon_byte_o, idle_fill());
    mute = 1'b0;
    q_d.push_back(8'h11); q_l.push_back(1'b1);
    wait_start();
    chk(mx_n_o == 1'b0 && err_o == 1'b0, "R8 error clears at next start", err_o, 0);
    drain();

    summary();
    $finish;
  end
endmodule